// File: doc/BRIEF.md
# Inter-Processor Message Mailbox

This block lets several processors on one chip pass 32-bit messages to each other through a small memory-mapped register file. It holds four mailboxes, and each one is a four-entry first-in first-out queue. A processor sends a message by writing it to a mailbox's message register. The receiving processor reads the same register, which removes the oldest word. For every mailbox there are two read-only registers: one gives the number of words waiting, the other reports whether the queue is full.

Four users, typically one per processor, watch the mailboxes through interrupts. Each mailbox produces two kinds of event: a word arrived, and the queue stopped being full. Every user has its own status register that latches these events and its own enable register that selects which events drive that user's interrupt line. A user acknowledges an event by writing a one to its status bit. A configuration register holds idle-related fields and a soft reset that clears itself. A system status bit shows when the soft reset has finished. A read-only revision register gives the version of the block.

Top module: `ipc_mailbox`

## Requirements
- R1: A write to the message register at byte offset 0x040 + 4*m stores the word in mailbox m. Reads of that offset return the stored words oldest first, one word per read.
- R2: The register at 0x0C0 + 4*m reads the number of words held in mailbox m. The register at 0x080 + 4*m reads non-zero when mailbox m holds 4 words and reads 0 otherwise.
- R3: A write to a mailbox that already holds 4 words is dropped. The count stays 4 and the stored words are unchanged.
- R4: A read of an empty mailbox's message register returns 0. The count and the event status do not change.
- R5: When a word is accepted into mailbox m, bit 2*m is set in the status register of every user.
- R6: When a read takes mailbox m out of the full state, bit 2*m+1 is set in the status register of every user.
- R7: The status register of user u is at 0x100 + 8*u. Writing 1 to a bit clears it, and writing 0 to a bit leaves it as it was. Only the addressed user's register changes.
- R8: The enable register of user u is at 0x104 + 8*u. Its low 8 bits read back as written and the upper bits read 0. Interrupt line u is high exactly when some bit is set in both user u's status and enable registers.
- R9: The configuration register at 0x010 reads back bit 0 and bits 4:3 as written. Bit 1, the soft reset, reads 1 for one cycle after it is set and then reads 0.
- R10: A soft reset empties every mailbox and clears every status and enable register. After that, bit 0 of the register at 0x014 reads 1, and it stays 1 until the next reset.
- R11: The register at 0x000 reads {major, minor} in bits 7:4 and 3:0 (default 0x12). Writes to it are ignored, and offsets that map to no register read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 9 | Byte address of the access |
| busWrEn | input | 1 | Write strobe, one access per cycle |
| busRdEn | input | 1 | Read strobe; a read of a message register removes a word |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data, valid in the same cycle as busRdEn |
| userIrq | output | 4 | Interrupt line of each user |

## Verification
The assertions assume that no cycle has both a read and a write, and that each access lasts exactly one cycle. Under those assumptions, a change to a mailbox count or to a status bit can be traced to a single decoded access. Every bench task drives one strobe for one clock and releases it before the next access starts, so the assumptions always hold. Some assertions would be disturbed by a flush in the same cycle, so they exclude cycles in which a soft reset is pending.

// File: rtl/ipc_mailbox_pkg.sv
package ipc_mailbox_pkg;
  parameter int NUM_MBOX   = 4;
  parameter int NUM_USER   = 4;
  parameter int FIFO_DEPTH = 4;
  parameter int DATA_W     = 32;
  parameter int ADDR_W     = 9;

  localparam int EVT_W  = 2 * NUM_MBOX;
  localparam int CNT_W  = $clog2(FIFO_DEPTH + 1);
  localparam int PTR_W  = (FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1;
  localparam int WORD_W = ADDR_W - 2;

  // word indices (byte offset / 4)
  localparam int REV_WORD = 'h00;
  localparam int CFG_WORD = 'h04;
  localparam int SYS_WORD = 'h05;
  localparam int MSG_BASE = 'h10;
  localparam int FST_BASE = 'h20;
  localparam int CNT_BASE = 'h30;
  localparam int IRQ_BASE = 'h40;

  typedef struct packed {
    logic [NUM_MBOX-1:0] push;
    logic [NUM_MBOX-1:0] pop;
    logic [NUM_USER-1:0] stsClr;
    logic [NUM_USER-1:0] enWr;
    logic                flush;
    logic [DATA_W-1:0]   wrData;
  } mbox_strobe_t;
endpackage

// File: rtl/mbox_datapath.sv
module mbox_datapath
  import ipc_mailbox_pkg::*;
(
  input  logic                                 clk,
  input  logic                                 rstN,
  input  mbox_strobe_t                         strb,
  output logic [NUM_MBOX-1:0][CNT_W-1:0]       fifoCount,
  output logic [NUM_MBOX-1:0][DATA_W-1:0]      headData,
  output logic [NUM_USER-1:0][EVT_W-1:0]       userStatus,
  output logic [NUM_USER-1:0][EVT_W-1:0]       userEnable,
  output logic [NUM_USER-1:0]                  userIrq
);
  logic [EVT_W-1:0] evt;
  logic unusedWrHi;
  assign unusedWrHi = &{1'b0, strb.wrData[DATA_W-1:EVT_W]};

  for (genvar m = 0; m < NUM_MBOX; m++) begin : g_fifo
    logic [DATA_W-1:0] mem [FIFO_DEPTH];
    logic [PTR_W-1:0]  rdPtr, wrPtr;
    logic [CNT_W-1:0]  cnt;
    logic              isFull, pushOk, popOk;

    assign isFull = (cnt == CNT_W'(FIFO_DEPTH));
    assign pushOk = strb.push[m] && !isFull;
    assign popOk  = strb.pop[m] && (cnt != '0);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        rdPtr <= '0;
        wrPtr <= '0;
        cnt   <= '0;
      end else if (strb.flush) begin
        rdPtr <= '0;
        wrPtr <= '0;
        cnt   <= '0;
      end else begin
        if (pushOk)
          wrPtr <= (wrPtr == PTR_W'(FIFO_DEPTH - 1)) ? '0 : wrPtr + 1'b1;
        if (popOk)
          rdPtr <= (rdPtr == PTR_W'(FIFO_DEPTH - 1)) ? '0 : rdPtr + 1'b1;
        if (pushOk && !popOk)
          cnt <= cnt + 1'b1;
        else if (popOk && !pushOk)
          cnt <= cnt - 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (pushOk && !strb.flush)
        mem[wrPtr] <= strb.wrData;
    end

    assign fifoCount[m]  = cnt;
    assign headData[m]   = (cnt == '0) ? '0 : mem[rdPtr];
    assign evt[2*m]      = pushOk && !strb.flush;
    assign evt[2*m+1]    = popOk && isFull && !strb.flush;
  end

  for (genvar u = 0; u < NUM_USER; u++) begin : g_user
    logic [EVT_W-1:0] sts, en, clrMask;

    assign clrMask = strb.stsClr[u] ? strb.wrData[EVT_W-1:0] : '0;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        sts <= '0;
        en  <= '0;
      end else if (strb.flush) begin
        sts <= '0;
        en  <= '0;
      end else begin
        sts <= (sts & ~clrMask) | evt;
        if (strb.enWr[u])
          en <= strb.wrData[EVT_W-1:0];
      end
    end

    assign userStatus[u] = sts;
    assign userEnable[u] = en;
    assign userIrq[u]    = |(sts & en);
  end
endmodule

// File: rtl/mbox_ctrl.sv
module mbox_ctrl
  import ipc_mailbox_pkg::*;
#(
  parameter logic [3:0] REV_MAJOR = 4'd1,
  parameter logic [3:0] REV_MINOR = 4'd2
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic [ADDR_W-1:0]               busAddr,
  input  logic                            busWrEn,
  input  logic                            busRdEn,
  input  logic [DATA_W-1:0]               busWrData,
  input  logic [NUM_MBOX-1:0][CNT_W-1:0]  fifoCount,
  input  logic [NUM_MBOX-1:0][DATA_W-1:0] headData,
  input  logic [NUM_USER-1:0][EVT_W-1:0]  userStatus,
  input  logic [NUM_USER-1:0][EVT_W-1:0]  userEnable,
  output mbox_strobe_t                    strb,
  output logic [DATA_W-1:0]               busRdData,
  output logic                            softRstPending
);
  logic [WORD_W-1:0] wordIdx;
  logic              aligned;
  logic              autoIdle;
  logic [1:0]        idleMode;
  logic              resetDone;

  assign wordIdx = busAddr[ADDR_W-1:2];
  assign aligned = (busAddr[1:0] == 2'b00);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      autoIdle       <= 1'b0;
      idleMode       <= 2'b00;
      softRstPending <= 1'b0;
      resetDone      <= 1'b1;
    end else begin
      if (softRstPending) begin
        softRstPending <= 1'b0;
        resetDone      <= 1'b1;
      end
      if (busWrEn && aligned && wordIdx == WORD_W'(CFG_WORD)) begin
        autoIdle <= busWrData[0];
        idleMode <= busWrData[4:3];
        if (busWrData[1]) begin
          softRstPending <= 1'b1;
          resetDone      <= 1'b0;
        end
      end
    end
  end

  always_comb begin
    strb        = '0;
    strb.flush  = softRstPending;
    strb.wrData = busWrData;
    for (int m = 0; m < NUM_MBOX; m++) begin
      if (aligned && wordIdx == WORD_W'(MSG_BASE + m)) begin
        strb.push[m] = busWrEn;
        strb.pop[m]  = busRdEn;
      end
    end
    for (int u = 0; u < NUM_USER; u++) begin
      if (aligned && wordIdx == WORD_W'(IRQ_BASE + 2*u))
        strb.stsClr[u] = busWrEn;
      if (aligned && wordIdx == WORD_W'(IRQ_BASE + 2*u + 1))
        strb.enWr[u] = busWrEn;
    end
  end

  always_comb begin
    busRdData = '0;
    if (busRdEn && aligned) begin
      if (wordIdx == WORD_W'(REV_WORD))
        busRdData = DATA_W'({REV_MAJOR, REV_MINOR});
      if (wordIdx == WORD_W'(CFG_WORD))
        busRdData = DATA_W'({idleMode, 1'b0, softRstPending, autoIdle});
      if (wordIdx == WORD_W'(SYS_WORD))
        busRdData = DATA_W'(resetDone);
      for (int m = 0; m < NUM_MBOX; m++) begin
        if (wordIdx == WORD_W'(MSG_BASE + m))
          busRdData = headData[m];
        if (wordIdx == WORD_W'(FST_BASE + m))
          busRdData = DATA_W'(fifoCount[m] == CNT_W'(FIFO_DEPTH));
        if (wordIdx == WORD_W'(CNT_BASE + m))
          busRdData = DATA_W'(fifoCount[m]);
      end
      for (int u = 0; u < NUM_USER; u++) begin
        if (wordIdx == WORD_W'(IRQ_BASE + 2*u))
          busRdData = DATA_W'(userStatus[u]);
        if (wordIdx == WORD_W'(IRQ_BASE + 2*u + 1))
          busRdData = DATA_W'(userEnable[u]);
      end
    end
  end
endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox
  import ipc_mailbox_pkg::*;
#(
  parameter logic [3:0] REV_MAJOR = 4'd1,
  parameter logic [3:0] REV_MINOR = 4'd2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  output logic [NUM_USER-1:0] userIrq
);
  mbox_strobe_t                    strb;
  logic [NUM_MBOX-1:0][CNT_W-1:0]  fifoCount;
  logic [NUM_MBOX-1:0][DATA_W-1:0] headData;
  logic [NUM_USER-1:0][EVT_W-1:0]  userStatus;
  logic [NUM_USER-1:0][EVT_W-1:0]  userEnable;
  logic                            softRstPending;

  mbox_ctrl #(.REV_MAJOR(REV_MAJOR), .REV_MINOR(REV_MINOR)) u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busRdEn(busRdEn), .busWrData(busWrData), .fifoCount(fifoCount),
    .headData(headData), .userStatus(userStatus), .userEnable(userEnable),
    .strb(strb), .busRdData(busRdData), .softRstPending(softRstPending)
  );

  mbox_datapath u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .fifoCount(fifoCount),
    .headData(headData), .userStatus(userStatus), .userEnable(userEnable),
    .userIrq(userIrq)
  );
endmodule

// File: rtl/ipc_mailbox_checker.sv
module ipc_mailbox_checker
  import ipc_mailbox_pkg::*;
(
  input logic                           clk,
  input logic                           rstN,
  input logic [ADDR_W-1:0]              busAddr,
  input logic                           busWrEn,
  input logic                           busRdEn,
  input logic [NUM_MBOX-1:0][CNT_W-1:0] fifoCount,
  input logic [NUM_USER-1:0][EVT_W-1:0] userStatus,
  input logic                           softRstPending,
  input logic [NUM_USER-1:0]            userIrq
);
  AST_SRST_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    softRstPending |=> !softRstPending); // R9

  AST_SRST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    softRstPending |=> (userIrq == '0)); // R10

  for (genvar m = 0; m < NUM_MBOX; m++) begin : g_mb
    logic hitMsg;
    assign hitMsg = (busAddr == ADDR_W'('h040 + 4*m));

    AST_COUNT_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
      fifoCount[m] <= CNT_W'(FIFO_DEPTH)); // R3

    AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rstN)
      (busWrEn && hitMsg && fifoCount[m] == CNT_W'(FIFO_DEPTH) && !softRstPending)
      |=> fifoCount[m] == CNT_W'(FIFO_DEPTH)); // R3

    AST_EMPTY_POP_HOLD: assert property (@(posedge clk) disable iff (!rstN)
      (busRdEn && hitMsg && fifoCount[m] == '0) |=> fifoCount[m] == '0); // R4

    AST_SRST_EMPTIES: assert property (@(posedge clk) disable iff (!rstN)
      softRstPending |=> fifoCount[m] == '0); // R10

    for (genvar u = 0; u < NUM_USER; u++) begin : g_us
      AST_NEWMSG_FANOUT: assert property (@(posedge clk) disable iff (!rstN)
        (busWrEn && !busRdEn && hitMsg && fifoCount[m] < CNT_W'(FIFO_DEPTH) && !softRstPending)
        |=> userStatus[u][2*m]); // R5
    end
  end
endmodule

bind ipc_mailbox ipc_mailbox_checker u_chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
  .busRdEn(busRdEn), .fifoCount(fifoCount), .userStatus(userStatus),
  .softRstPending(softRstPending), .userIrq(userIrq)
);

// File: tb/ipc_mailbox_test.sv
module ipc_mailbox_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [8:0]  busAddr = '0;
  logic        busWrEn = 1'b0;
  logic        busRdEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic [3:0]  userIrq;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  ipc_mailbox uut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busRdEn(busRdEn), .busWrData(busWrData), .busRdData(busRdData),
    .userIrq(userIrq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(posedge clk); #1;
    busWrEn = 1'b0;
  endtask

  task automatic rd(input logic [8:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a; busRdEn = 1'b1;
    #2 d = busRdData;
    @(posedge clk); #1;
    busRdEn = 1'b0;
  endtask

  task automatic rdCheck(input string req, input logic [8:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    check(req, d, exp);
  endtask

  task automatic clearAll();
    for (int u = 0; u < 4; u++) wr(9'(9'h100 + 8*u), 32'hFF);
  endtask

  task automatic testReset();
    check("R8 irq after reset", 32'(userIrq), 32'h0);
    rdCheck("R11 revision", 9'h000, 32'h12);
    rdCheck("R10 reset done", 9'h014, 32'h1);
    rdCheck("R2 count empty", 9'h0C0, 32'h0);
    rdCheck("R9 config reset", 9'h010, 32'h0);
  endtask

  task automatic testOrder();
    wr(9'h044, 32'h11); wr(9'h044, 32'h22); wr(9'h044, 32'h33);
    rdCheck("R2 count three", 9'h0C4, 32'd3);
    rdCheck("R1 first out", 9'h044, 32'h11);
    rdCheck("R1 second out", 9'h044, 32'h22);
    rdCheck("R2 count one", 9'h0C4, 32'd1);
  endtask

  task automatic testFull();
    logic [31:0] d;
    for (int i = 0; i < 4; i++) wr(9'h048, 32'hA0 + 32'(i));
    rd(9'h088, d);
    check("R2 full status nonzero", 32'(d != 0), 32'h1);
    wr(9'h048, 32'hFF);
    rdCheck("R3 count stays 4", 9'h0C8, 32'd4);
    clearAll();
    rdCheck("R3 oldest kept", 9'h048, 32'hA0);
    rdCheck("R6 not-full user0", 9'h100, 32'h20);
    rdCheck("R6 not-full user3", 9'h118, 32'h20);
    rdCheck("R2 not full status", 9'h088, 32'h0);
    rdCheck("R3 word 1", 9'h048, 32'hA1);
    rdCheck("R3 word 2", 9'h048, 32'hA2);
    rdCheck("R3 word 3", 9'h048, 32'hA3);
    rdCheck("R3 dropped word absent", 9'h0C8, 32'h0);
  endtask

  task automatic testEmpty();
    clearAll();
    rdCheck("R4 empty read zero", 9'h040, 32'h0);
    rdCheck("R4 count unchanged", 9'h0C0, 32'h0);
    rdCheck("R4 status unchanged", 9'h100, 32'h0);
  endtask

  task automatic testW1c();
    clearAll();
    wr(9'h040, 32'h55);
    rdCheck("R5 newmsg user2", 9'h110, 32'h1);
    rdCheck("R5 newmsg user0", 9'h100, 32'h1);
    wr(9'h110, 32'h0);
    rdCheck("R7 zero write keeps", 9'h110, 32'h1);
    wr(9'h110, 32'h1);
    rdCheck("R7 one write clears", 9'h110, 32'h0);
    rdCheck("R7 other user kept", 9'h100, 32'h1);
    rdCheck("R1 drain", 9'h040, 32'h55);
    rdCheck("R6 no notfull when not full", 9'h100, 32'h1);
  endtask

  task automatic testIrq();
    clearAll();
    wr(9'h11C, 32'h1);
    rdCheck("R8 enable readback", 9'h11C, 32'h1);
    check("R8 irq idle", 32'(userIrq), 32'h0);
    wr(9'h040, 32'h77);
    check("R8 irq user3", 32'(userIrq), 32'h8);
    wr(9'h11C, 32'h0);
    check("R8 irq masked", 32'(userIrq), 32'h0);
    wr(9'h10C, 32'hFFFF_FFFF);
    rdCheck("R8 enable width", 9'h10C, 32'hFF);
    check("R8 irq user1", 32'(userIrq), 32'h2);
    rdCheck("R11 unused offset", 9'h0FC, 32'h0);
    wr(9'h000, 32'hFFFF);
    rdCheck("R11 revision read-only", 9'h000, 32'h12);
  endtask

  task automatic testSoftReset();
    wr(9'h010, 32'h13);
    rdCheck("R9 soft reset visible", 9'h010, 32'h13);
    rdCheck("R10 reset done after", 9'h014, 32'h1);
    rdCheck("R9 soft reset cleared", 9'h010, 32'h11);
    rdCheck("R10 mbox0 emptied", 9'h0C0, 32'h0);
    rdCheck("R10 mbox1 emptied", 9'h0C4, 32'h0);
    rdCheck("R10 enable cleared", 9'h10C, 32'h0);
    rdCheck("R10 status cleared", 9'h108, 32'h0);
    check("R10 irq cleared", 32'(userIrq), 32'h0);
    wr(9'h010, 32'h18);
    rdCheck("R9 idle field", 9'h010, 32'h18);
    rdCheck("R10 reset done holds", 9'h014, 32'h1);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    testReset();
    testOrder();
    testFull();
    testEmpty();
    testW1c();
    testIrq();
    testSoftReset();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule